// File: doc/BRIEF.md
# MDIO Management Master Controller

This block is the station-management master of an Ethernet MAC subsystem. Software reaches it through a small word-addressed register bus. It runs one Clause 22 management frame at a time toward an external PHY over the MDC clock pin and the shared MDIO data pin. The data pin is split into an input, an output and an output enable, so that the pad ring can build the tri-state buffer.

Software first writes the control word. This turns the controller on and sets the MDC divider. To start a read or a write, software writes the access word with the start bit set, then polls that bit until it clears. For a read, the returned data and the acknowledge flag are valid once the start bit has cleared. MDC toggles only while a frame is on the wire. MDIO changes one clock cycle after each MDC rising edge, and read data from the PHY is captured on the MDC rising edge.

The register bus has two words. Word address 0 is the control word and word address 1 is the access word. Read data is registered and appears in the cycle after the read.

Top module: `mdio_master`

## Requirements
- R1: After reset, the control word reads 0x800000FF: bit 31 (idle) is 1, bit 30 (enable) is 0, bits 19 and 18 are 0, and bits 15:0 (divider) hold 0x00FF. The access word reads 0, MDC is low and the MDIO output enable is 0.
- R2: In the control word, bit 30 (enable), bit 19 (fault flag), bit 18 (fault enable) and bits 15:0 (divider) read back what was written. Bit 31 is read-only and reads 1 exactly when enable is 0 and no frame is in progress.
- R3: While a frame runs, MDC has a period of (divider+1) clock cycles. A divider of 0 behaves like 1. MDC is low whenever no frame is in progress.
- R4: Writing the access word (address 1) with bit 31 (GO) set starts a frame when the controller is enabled and idle. GO then reads 1 until the frame has completed and clears by itself afterwards.
- R5: A frame is 64 MDC cycles long: 32 ones, then 01, then the opcode (10 read, 01 write), then the 5-bit PHY address (access bits 20:16), then the 5-bit register address (access bits 25:21), then the turnaround, then 16 data bits. All multi-bit fields are sent MSB first. Bit 30 of the access word selects a write (1) or a read (0). A write drives turnaround 10 and data bits 15:0, with the output enable high for the whole frame.
- R6: A read drops the output enable from the first turnaround bit to the end of the frame. The 16 bits sampled on the following MDC rising edges then read back in access bits 15:0.
- R7: Access bit 29 (ACK) reads 1 after a read only if MDIO was low at the second turnaround bit. It reads 0 after a read that got no answer and after any write.
- R8: A write to the access word while GO is 1 changes no field and starts no frame. A GO write while the controller is disabled starts nothing: MDC stays low and GO stays 0.
- R9: Clearing enable while a frame runs lets that frame finish. Idle (control bit 31) rises only once the frame has completed.
- R10: While MDC is high, the MDIO output changes only in the first clock cycle after the MDC rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address: 0 control, 1 access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO pin input |
| mdio_o | output | 1 | MDIO pin output value |
| mdio_oe | output | 1 | MDIO pin output enable |

## Verification
A model PHY on the bench replies to reads, or stays silent behind a pull-up. This covers both acknowledge outcomes: a controller that checks the wrong turnaround bit, or keeps driving during turnaround, either reports ACK for a silent PHY or corrupts the returned word. The bench measures the MDC period at divider values 3, 4 and 0, which would expose an off-by-one in the divider or a broken divide-by-zero case. It fires a second start while a frame is running and another while the controller is disabled; a design without the guard would either overwrite the live fields or put an extra frame on the wire. Disabling in mid-frame checks that the idle flag does not rise while bits are still going out.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_W       = 32;
  localparam int DIV_W       = 16;
  localparam int FRAME_BITS  = 64;
  localparam int IDX_W       = $clog2(FRAME_BITS);
  localparam int TA_FIRST    = 46;
  localparam int TA_LAST     = 47;
  localparam int DATA_FIRST  = 48;
  // control word fields
  localparam int CB_IDLE     = 31;
  localparam int CB_EN       = 30;
  localparam int CB_FAULT    = 19;
  localparam int CB_FEN      = 18;
  // access word fields
  localparam int UB_GO       = 31;
  localparam int UB_WR       = 30;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] data;
  } mdio_req_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             rise_d
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;
  logic [DIV_W-1:0] half;

  always_comb begin
    div_eff = (div == '0) ? DIV_W'(1) : div;
    half    = DIV_W'((32'(div_eff) + 32'd1) >> 1);
    rise    = run && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= (cnt == div_eff) ? '0 : cnt + 1'b1;
      if (rise)              mdc <= 1'b1;
      else if (cnt == half)  mdc <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rise_d <= 1'b0;
    else     rise_d <= rise;
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  mdio_req_t        req,
  input  logic             rise,
  input  logic             rise_d,
  input  logic             mdio_i,
  output logic             busy,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             wr,
  output logic [4:0]       phy,
  output logic [4:0]       regad,
  output logic [15:0]      data,
  output logic             ack,
  output logic [IDX_W-1:0] idx
);
  logic [FRAME_BITS-1:0] sh;
  logic [FRAME_BITS-1:0] frame_w;
  logic [15:0]           rd_sh;
  logic                  ack_cap;
  logic [IDX_W-1:0]      idx_nx;

  always_comb begin
    frame_w = {32'hFFFF_FFFF, 2'b01, (req.wr ? OP_WR : OP_RD),
               req.phy, req.regad, 2'b10, req.data};
    idx_nx  = idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; mdio_o <= 1'b0; mdio_oe <= 1'b0;
      wr <= 1'b0; phy <= '0; regad <= '0; data <= '0; ack <= 1'b0;
      idx <= '0; sh <= '0; rd_sh <= '0; ack_cap <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      idx     <= '0;
      sh      <= frame_w;
      mdio_o  <= frame_w[FRAME_BITS-1];
      mdio_oe <= 1'b1;
      wr      <= req.wr;
      phy     <= req.phy;
      regad   <= req.regad;
      data    <= req.data;
      ack     <= 1'b0;
      ack_cap <= 1'b0;
    end else if (busy) begin
      if (rise && !wr) begin
        if (idx == IDX_W'(TA_LAST))     ack_cap <= !mdio_i;
        if (idx >= IDX_W'(DATA_FIRST))  rd_sh   <= {rd_sh[14:0], mdio_i};
      end
      if (rise_d) begin
        if (idx == IDX_W'(FRAME_BITS-1)) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b0;
          if (!wr) begin
            data <= rd_sh;
            ack  <= ack_cap;
          end
        end else begin
          idx     <= idx_nx;
          sh      <= {sh[FRAME_BITS-2:0], 1'b0};
          mdio_o  <= sh[FRAME_BITS-2];
          mdio_oe <= wr || (idx_nx < IDX_W'(TA_FIRST));
        end
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int               ADDR_W  = 2,
  parameter logic [DIV_W-1:0] DIV_RST = 16'h00FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              busy,
  input  logic              wr,
  input  logic [4:0]        phy,
  input  logic [4:0]        regad,
  input  logic [15:0]       data,
  input  logic              ack,
  output logic              enable,
  output logic [DIV_W-1:0]  div,
  output logic              start,
  output mdio_req_t         req
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_USER = ADDR_W'(1);

  logic fault_q, fen_q, idle;
  logic [REG_W-1:0] ctrl_word, user_word;

  always_comb begin
    idle      = !enable && !busy;
    start     = bus_en && bus_we && (bus_addr == A_USER) &&
                bus_wdata[UB_GO] && enable && !busy;
    req.wr    = bus_wdata[UB_WR];
    req.regad = bus_wdata[25:21];
    req.phy   = bus_wdata[20:16];
    req.data  = bus_wdata[15:0];
    ctrl_word = {idle, enable, 10'b0, fault_q, fen_q, 2'b0, div};
    user_word = {busy, wr, ack, 3'b0, regad, phy, data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable  <= 1'b0;
      fault_q <= 1'b0;
      fen_q   <= 1'b0;
      div     <= DIV_RST;
    end else if (bus_en && bus_we && bus_addr == A_CTRL) begin
      enable  <= bus_wdata[CB_EN];
      fault_q <= bus_wdata[CB_FAULT];
      fen_q   <= bus_wdata[CB_FEN];
      div     <= bus_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_en && !bus_we) begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= ctrl_word;
        A_USER:  bus_rdata <= user_word;
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int               ADDR_W  = 2,
  parameter logic [DIV_W-1:0] DIV_RST = 16'h00FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic             start_w, busy_w, enable_w, rise_w, rise_d_w;
  logic             wr_w, ack_w;
  logic [4:0]       phy_w, reg_w;
  logic [15:0]      data_w;
  logic [DIV_W-1:0] div_w;
  logic [IDX_W-1:0] idx_w;
  mdio_req_t        req_w;

  mdio_regs #(.ADDR_W(ADDR_W), .DIV_RST(DIV_RST)) regs_i (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy_w), .wr(wr_w), .phy(phy_w), .regad(reg_w), .data(data_w),
    .ack(ack_w), .enable(enable_w), .div(div_w), .start(start_w), .req(req_w)
  );

  mdio_clkgen clkgen_i (
    .clk(clk), .rst(rst), .run(busy_w), .div(div_w),
    .mdc(mdc), .rise(rise_w), .rise_d(rise_d_w)
  );

  mdio_frame frame_i (
    .clk(clk), .rst(rst), .start(start_w), .req(req_w),
    .rise(rise_w), .rise_d(rise_d_w), .mdio_i(mdio_i),
    .busy(busy_w), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .wr(wr_w), .phy(phy_w), .regad(reg_w), .data(data_w),
    .ack(ack_w), .idx(idx_w)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             enable,
  input logic             wr,
  input logic             ack,
  input logic [IDX_W-1:0] idx,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe
);
  // R8: a frame only ever begins while the controller was enabled
  p_start_enabled_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(enable));

  // R3: MDC rests low once no frame was running in the prior cycle
  p_mdc_rest_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(busy) |-> !mdc);

  // R6: pin released from the turnaround onward during a read
  p_release_ta_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !wr && idx >= IDX_W'(TA_FIRST)) |-> !mdio_oe);

  // R7: no acknowledge reported while a write frame runs
  p_ack_write_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && wr) |-> !ack);

  // R10: output moves only right after the MDC rising edge
  p_out_after_rise_r10: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc) && !$stable(mdio_o)) |-> !$past(mdc, 2));
endmodule

bind mdio_master mdio_master_chk chk_i (
  .clk(clk), .rst(rst), .busy(busy_w), .enable(enable_w), .wr(wr_w),
  .ack(ack_w), .idx(idx_w), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_i, mdio_o, mdio_oe;

  int vecs = 0, fails = 0;
  logic [127:0] sbq[$];
  int exp_period = 4;
  int rise_total = 0;

  // PHY model state
  logic        phy_respond = 1'b0;
  logic [15:0] phy_data = '0;
  logic        phy_en = 1'b0, phy_v = 1'b1;
  assign mdio_i = phy_en ? phy_v : 1'b1;

  always #5 clk = ~clk;

  mdio_master dut_i (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] acc_word(logic go, logic wr, logic ack,
                                          logic [4:0] rg, logic [4:0] ph, logic [15:0] d);
    return {go, wr, ack, 3'b000, rg, ph, d};
  endfunction

  // driver: push the expected frame and oe pattern, then issue GO
  task automatic start_frame(input logic wr, input logic [4:0] ph, input logic [4:0] rg,
                             input logic [15:0] d, input logic resp, input logic [15:0] pd);
    logic [63:0] f, oe;
    phy_respond = resp; phy_data = pd;
    if (wr) begin
      f  = {32'hFFFF_FFFF, 2'b01, 2'b01, ph, rg, 2'b10, d};
      oe = '1;
    end else begin
      f  = {32'hFFFF_FFFF, 2'b01, 2'b10, ph, rg, 1'b1, !resp, resp ? pd : 16'hFFFF};
      oe = {{46{1'b1}}, {18{1'b0}}};
    end
    sbq.push_back({f, oe});
    bus_write(2'd1, acc_word(1'b1, wr, 1'b0, rg, ph, d));
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int n = 0; n < 3000; n++) begin
      bus_read(2'd1, v);
      if (!v[31]) return;
    end
    vecs++; fails++;
    $display("FAIL R4: GO stuck, got %h expected bit31 clear", v);
  endtask

  // monitor + PHY: observe each MDC rise, rebuild the frame, compare
  logic        mdc_q = 1'b0;
  int          bitn = 0, cyc = 0, last = 0;
  logic [63:0] fr = '0, oev = '0;
  logic        is_rd = 1'b0, per_bad = 1'b0, line;
  logic [127:0] item;
  always @(negedge clk) begin
    if (rst) begin
      mdc_q = 1'b0; bitn = 0; phy_en = 1'b0;
    end else begin
      if (mdc && !mdc_q) begin
        line = mdio_oe ? mdio_o : (phy_en ? phy_v : 1'b1);
        fr   = {fr[62:0], line};
        oev  = {oev[62:0], mdio_oe};
        if (bitn == 0) per_bad = 1'b0;
        else if (cyc - last != exp_period) per_bad = 1'b1;
        last = cyc;
        rise_total++;
        if (bitn == 35) is_rd = (fr[1:0] == 2'b10);
        if (is_rd && phy_respond) begin
          if (bitn == 46) begin phy_en = 1'b1; phy_v = 1'b0; end
          if (bitn >= 47 && bitn <= 62) phy_v = phy_data[62 - bitn];
        end
        if (bitn == 63) begin
          phy_en = 1'b0;
          bitn = 0;
          vecs++;
          if (sbq.size() == 0) begin
            fails++;
            $display("FAIL R8: unexpected frame got %h expected none", fr);
          end else begin
            item = sbq.pop_front();
            if ({fr, oev} !== item) begin
              fails++;
              $display("FAIL R5 R6: frame got %h/%h expected %h/%h",
                       fr, oev, item[127:64], item[63:0]);
            end
          end
          vecs++;
          if (per_bad) begin
            fails++;
            $display("FAIL R3: MDC period got mismatch expected %0d", exp_period);
          end
        end else bitn++;
      end
      mdc_q = mdc;
      cyc++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    vecs++; fails++;
    $display("FAIL R4: watchdog got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, prev;
    int rt;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_read(2'd0, v); chk("R1 ctrl reset", v, 32'h8000_00FF);
    bus_read(2'd1, v); chk("R1 access reset", v, 32'h0);
    chk("R1 mdc/oe idle", {30'b0, mdc, mdio_oe}, 32'h0);

    // R2 control write/readback
    bus_write(2'd0, 32'h400C_0003); exp_period = 4;
    bus_read(2'd0, v); chk("R2 ctrl readback", v, 32'h400C_0003);

    // R4 write frame; R8 busy write ignored
    start_frame(1'b1, 5'd5, 5'h1A, 16'hBEEF, 1'b0, 16'h0);
    bus_read(2'd1, v); chk("R4 GO held", v, acc_word(1, 1, 0, 5'h1A, 5'd5, 16'hBEEF));
    bus_write(2'd1, acc_word(1, 0, 0, 5'd4, 5'd3, 16'h0000));
    bus_read(2'd1, v); chk("R8 busy write ignored", v, acc_word(1, 1, 0, 5'h1A, 5'd5, 16'hBEEF));
    wait_idle();
    bus_read(2'd1, v); chk("R4 R7 write done", v, acc_word(0, 1, 0, 5'h1A, 5'd5, 16'hBEEF));
    repeat (20) @(negedge clk);
    chk("R8 no extra frame", sbq.size(), 32'd0);

    // R6 R7 read with answer
    start_frame(1'b0, 5'h11, 5'd2, 16'h0, 1'b1, 16'h1234);
    wait_idle();
    bus_read(2'd1, v); chk("R6 R7 read ack", v, acc_word(0, 0, 1, 5'd2, 5'h11, 16'h1234));

    // R7 silent PHY
    start_frame(1'b0, 5'd7, 5'd3, 16'h0, 1'b0, 16'h0);
    wait_idle();
    bus_read(2'd1, v); chk("R7 no answer", v, acc_word(0, 0, 0, 5'd3, 5'd7, 16'hFFFF));

    // R3 divider 4 with boundary addresses
    bus_write(2'd0, 32'h4000_0004); exp_period = 5;
    start_frame(1'b1, 5'h1F, 5'h1F, 16'h0001, 1'b0, 16'h0);
    wait_idle();
    bus_read(2'd1, v); chk("R5 max addr write", v, acc_word(0, 1, 0, 5'h1F, 5'h1F, 16'h0001));

    // R3 divider 0 acts as 1
    bus_write(2'd0, 32'h4000_0000); exp_period = 2;
    bus_read(2'd0, v); chk("R2 idle low when enabled", v, 32'h4000_0000);
    start_frame(1'b0, 5'd1, 5'd0, 16'h0, 1'b1, 16'h8001);
    wait_idle();
    bus_read(2'd1, v); chk("R6 read div0", v, acc_word(0, 0, 1, 5'd0, 5'd1, 16'h8001));

    // R9 disable in mid-frame
    bus_write(2'd0, 32'h4000_0001);
    start_frame(1'b1, 5'd2, 5'd9, 16'h5A5A, 1'b0, 16'h0);
    bus_write(2'd0, 32'h0000_0001);
    bus_read(2'd0, v); chk("R9 idle held while busy", v, 32'h0000_0001);
    wait_idle();
    bus_read(2'd0, v); chk("R9 idle after frame", v, 32'h8000_0001);

    // R8 GO while disabled
    bus_read(2'd1, prev);
    rt = rise_total;
    bus_write(2'd1, acc_word(1, 0, 0, 5'd6, 5'd6, 16'h0));
    repeat (40) @(negedge clk);
    chk("R8 disabled no MDC", rise_total, rt);
    bus_read(2'd1, v); chk("R8 disabled no start", v, prev);
    chk("R8 expected frames consumed", sbq.size(), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule